// File: doc/BRIEF.md
# Accessory Bus Byte Serial Port

This block moves single bytes over a one-wire accessory line using asynchronous framing. The line idles high. Each frame is a low start bit, eight data bits sent least significant bit first, and a high stop bit. Software reaches the block through three byte-wide registers on a simple strobe bus:

- a control register, which holds the rate code, the transmit and receive mode bits, and a self-clearing busy bit;
- a status register, for polling;
- a data register, shared by both directions.

The bit period comes from a divider on the system clock. The divider is the system clock rate divided by the selected bit rate, rounded to the nearest integer.

Software uses the block in a fixed pattern. It sets the busy bit once, which clears the shift logic, and waits until the bit reads 0. It then turns on transmit mode around each outgoing message and writes one byte each time send-ready is high. Receive mode stays on while the accessory is expected to answer. Each incoming byte is collected when byte-available rises.

Top module: `acc_serial_port`

## Requirements
- R1: Control bits 2:0 select the bit rate. Code 001 is 19200, code 011 is 57600 and code 100 is 115200. Every other code (000, 010, 101, 110, 111) gives 9600. One bit lasts round(CLK_HZ / rate) clock cycles.
- R2: A write to the data register (address 2) that is accepted drives txd low on the clock edge that takes the write. txd then shows the start bit, data bits 0 to 7 and a high stop bit, each lasting one bit period. txd is high whenever the line is idle.
- R3: Status bit 4 (send-ready) reads 0 from the accepting edge until exactly ten bit periods later, then reads 1 again.
- R4: A data write is ignored when control bit 5 (transmit mode) is 0, and also while send-ready is 0.
- R5: With control bit 6 (receive mode) at 1, an incoming frame is sampled at the middle of each bit. The byte is kept only if the stop bit is high, and status bit 5 (byte-available) is then set. With receive mode at 0, frames are not captured.
- R6: A low pulse on rxd that is no longer high... that has already returned high at the middle of the start bit is dropped. It captures nothing.
- R7: Reading the data register returns the last received byte and clears byte-available.
- R8: Status bits 2:0 give the number of data bits of the current byte shifted so far, modulo 8. The transmitter's count is shown while it is active; otherwise the receiver's count is shown.
- R9: Writing 1 to control bit 7 (busy) sets that bit for exactly 16 cycles, after which it reads 0. While it is set, a frame in progress is abandoned (txd high, send-ready 1, count 0) and data writes are ignored.
- R10: After reset, txd is 1, control reads 0x00, status reads 0x10 and data reads 0x00.
- R11: reg_rdata is registered. A read taken on one edge shows, after that edge, the register value from just before it. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rxd | input | 1 | Serial line input, asynchronous |
| txd | output | 1 | Serial line output |

## Verification
The bench counts clock edges from reset and places every action on a numbered edge.

- **Transmit line:** once a data write is accepted on edge E, bit k of the frame appears on txd after edge E + k·D, where D is the divider. txd is sampled half a period later.
- **Send-ready:** it returns after edge E + 10·D. It is probed by reads taken on edges E + 10·D and E + 10·D + 1, which must give 0 and 1.
- **Register reads:** these take effect one edge after the strobe.
- **Busy:** reads taken 16 and 17 edges after the control write must show 1 and then 0.
- **Received bytes:** these pass through a two-stage synchronizer and a half-period start check. The bench therefore waits at least half a period past the end of the frame before it checks byte-available.

// File: rtl/asp_pkg.sv
package asp_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_TXMODE = 5;
  localparam int CTRL_RXMODE = 6;
  localparam int CTRL_BUSY   = 7;
  localparam int STAT_READY  = 4;
  localparam int STAT_AVAIL  = 5;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_DATA  = 2'd2,
    SH_STOP  = 2'd3
  } shift_state_e;

  function automatic int bit_div(input int clk_hz, input int rate);
    return (clk_hz + rate / 2) / rate;
  endfunction

endpackage

// File: rtl/asp_baud_sel.sv
module asp_baud_sel #(
  parameter int CLK_HZ = 13_000_000,
  parameter int DIV_W  = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       code_i,
  output logic [DIV_W-1:0] div_o
);
  localparam int D_9600   = asp_pkg::bit_div(CLK_HZ, 9600);
  localparam int D_19200  = asp_pkg::bit_div(CLK_HZ, 19200);
  localparam int D_57600  = asp_pkg::bit_div(CLK_HZ, 57600);
  localparam int D_115200 = asp_pkg::bit_div(CLK_HZ, 115200);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o <= DIV_W'(D_9600);
    end else begin
      case (code_i)
        3'b001:  div_o <= DIV_W'(D_19200);
        3'b011:  div_o <= DIV_W'(D_57600);
        3'b100:  div_o <= DIV_W'(D_115200);
        default: div_o <= DIV_W'(D_9600);
      endcase
    end
  end

  AST_DIV_FOLLOWS_CODE: assert property (@(posedge clk) disable iff (rst)
    $stable(code_i) |=> $stable(div_o)); // R1

endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  output logic             txd_o,
  output logic             ready_o,
  output logic [2:0]       bitcnt_o
);
  import asp_pkg::*;

  shift_state_e     state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [7:0]       shift_q;
  logic [3:0]       bits_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      bits_q  <= '0;
      txd_o   <= 1'b1;
    end else begin
      case (state_q)
        SH_IDLE: begin
          txd_o <= 1'b1;
          if (load_i) begin
            state_q <= SH_START;
            txd_o   <= 1'b0;
            shift_q <= data_i;
            cnt_q   <= div_i - 1'b1;
            bits_q  <= '0;
          end
        end
        SH_START: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            state_q <= SH_DATA;
            txd_o   <= shift_q[0];
            shift_q <= {1'b0, shift_q[7:1]};
            cnt_q   <= div_i - 1'b1;
          end
        end
        SH_DATA: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            bits_q <= bits_q + 1'b1;
            cnt_q  <= div_i - 1'b1;
            if (bits_q == 4'd7) begin
              state_q <= SH_STOP;
              txd_o   <= 1'b1;
            end else begin
              txd_o   <= shift_q[0];
              shift_q <= {1'b0, shift_q[7:1]};
            end
          end
        end
        default: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            state_q <= SH_IDLE;
            bits_q  <= '0;
          end
        end
      endcase
    end
  end

  assign ready_o  = (state_q == SH_IDLE);
  assign bitcnt_o = bits_q[2:0];

  AST_TX_LOAD_START: assert property (@(posedge clk) disable iff (rst)
    (load_i && ready_o && !abort_i) |=> !txd_o); // R2

  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready_o) && !$past(abort_i)) |-> $past(txd_o)); // R2

endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int DIV_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             byte_valid_o,
  output logic [7:0]       byte_o,
  output logic             active_o,
  output logic [2:0]       bitcnt_o
);
  import asp_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;

  always_ff @(posedge clk) begin
    if (rst) sync_q[0] <= 1'b1;
    else     sync_q[0] <= rxd_i;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[g] <= 1'b1;
      else     sync_q[g] <= sync_q[g-1];
    end
  end

  assign line = sync_q[SYNC_STAGES-1];

  shift_state_e     state_q;
  logic [DIV_W-1:0] cnt_q;
  logic [7:0]       shift_q;
  logic [3:0]       bits_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      state_q      <= SH_IDLE;
      cnt_q        <= '0;
      shift_q      <= '0;
      bits_q       <= '0;
      byte_valid_o <= 1'b0;
      if (rst) byte_o <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      case (state_q)
        SH_IDLE: begin
          if (!line) begin
            state_q <= SH_START;
            cnt_q   <= (div_i >> 1) - 1'b1;
            bits_q  <= '0;
          end
        end
        SH_START: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (!line) begin
            state_q <= SH_DATA;
            cnt_q   <= div_i - 1'b1;
          end else begin
            state_q <= SH_IDLE;
          end
        end
        SH_DATA: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            shift_q <= {line, shift_q[7:1]};
            bits_q  <= bits_q + 1'b1;
            cnt_q   <= div_i - 1'b1;
            if (bits_q == 4'd7) state_q <= SH_STOP;
          end
        end
        default: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            state_q <= SH_IDLE;
            bits_q  <= '0;
            if (line) begin
              byte_o       <= shift_q;
              byte_valid_o <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign active_o = (state_q != SH_IDLE);
  assign bitcnt_o = bits_q[2:0];

  AST_RX_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> $past(en_i)); // R5

  AST_RX_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o |-> $past(line)); // R5

endmodule

// File: rtl/acc_serial_port.sv
module acc_serial_port #(
  parameter int CLK_HZ      = 13_000_000,
  parameter int BUSY_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  output logic       txd
);
  import asp_pkg::*;

  localparam int DIV_W  = $clog2(bit_div(CLK_HZ, 9600) + 1);
  localparam int BUSY_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

  logic [2:0]       baud_q;
  logic             tx_mode_q;
  logic             rx_mode_q;
  logic             busy_q;
  logic [BUSY_W-1:0] busy_cnt_q;
  logic             avail_q;
  logic [DIV_W-1:0] div;

  logic             tx_ready;
  logic [2:0]       tx_cnt;
  logic             rx_valid;
  logic [7:0]       rx_byte;
  logic             rx_active;
  logic [2:0]       rx_cnt;

  logic             ctrl_wr;
  logic             data_wr;
  logic             data_rd;
  logic             tx_load;
  logic [7:0]       ctrl_view;
  logic [7:0]       stat_view;
  logic             wdata_unused;

  assign ctrl_wr      = reg_wr && (reg_addr == ADDR_CTRL);
  assign data_wr      = reg_wr && (reg_addr == ADDR_DATA);
  assign data_rd      = reg_rd && (reg_addr == ADDR_DATA);
  assign tx_load      = data_wr && tx_mode_q && tx_ready && !busy_q;
  assign wdata_unused = ^reg_wdata[4:3];

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q     <= '0;
      tx_mode_q  <= 1'b0;
      rx_mode_q  <= 1'b0;
      busy_q     <= 1'b0;
      busy_cnt_q <= '0;
    end else begin
      if (busy_q) begin
        if (busy_cnt_q == '0) busy_q <= 1'b0;
        else                  busy_cnt_q <= busy_cnt_q - 1'b1;
      end
      if (ctrl_wr) begin
        baud_q    <= reg_wdata[2:0];
        tx_mode_q <= reg_wdata[CTRL_TXMODE];
        rx_mode_q <= reg_wdata[CTRL_RXMODE];
        if (reg_wdata[CTRL_BUSY]) begin
          busy_q     <= 1'b1;
          busy_cnt_q <= BUSY_W'(BUSY_CYCLES - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           avail_q <= 1'b0;
    else if (rx_valid) avail_q <= 1'b1;
    else if (data_rd)  avail_q <= 1'b0;
  end

  assign ctrl_view = {busy_q, rx_mode_q, tx_mode_q, 2'b00, baud_q};
  assign stat_view = {2'b00, avail_q, tx_ready, 1'b0,
                      tx_ready ? (rx_active ? rx_cnt : 3'd0) : tx_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= ctrl_view;
        ADDR_STAT: reg_rdata <= stat_view;
        ADDR_DATA: reg_rdata <= rx_byte;
        default:   reg_rdata <= '0;
      endcase
    end
  end

  asp_baud_sel #(.CLK_HZ(CLK_HZ), .DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst(rst), .code_i(baud_q), .div_o(div)
  );

  asp_tx #(.DIV_W(DIV_W)) tx_i (
    .clk(clk), .rst(rst), .abort_i(busy_q), .div_i(div),
    .load_i(tx_load), .data_i(reg_wdata),
    .txd_o(txd), .ready_o(tx_ready), .bitcnt_o(tx_cnt)
  );

  asp_rx #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) rx_i (
    .clk(clk), .rst(rst), .en_i(rx_mode_q && !busy_q), .div_i(div),
    .rxd_i(rxd), .byte_valid_o(rx_valid), .byte_o(rx_byte),
    .active_o(rx_active), .bitcnt_o(rx_cnt)
  );

  AST_BUSY_ABORTS_TX: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> tx_ready); // R9

  AST_READ_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rx_valid) |=> !avail_q); // R7

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !tx_mode_q && tx_ready) |=> tx_ready); // R4

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ($past(busy_cnt_q) == '0)); // R9

endmodule

// File: tb/acc_serial_port_tb.sv
module acc_serial_port_tb_top;
  localparam int CLK_HZ = 1_300_000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_drv = 1'b1;
  logic       lb = 1'b0;
  logic       txd;
  logic       rxd;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  assign rxd = lb ? txd : rx_drv;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  acc_serial_port #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd(rxd), .txd(txd)
  );

  // code, byte, expected bit period at CLK_HZ (R1 table)
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'hA5, 8'd135}, {3'd1, 8'h3C, 8'd68},
    {3'd2, 8'h01, 8'd135}, {3'd3, 8'h96, 8'd23},
    {3'd4, 8'h5A, 8'd11},  {3'd5, 8'h80, 8'd135},
    {3'd6, 8'h00, 8'd135}, {3'd7, 8'hC3, 8'd135}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Bus operation taken on edge 'at'; returns at the negedge after it.
  task automatic bus(input int at, input bit wr, input logic [1:0] a, input logic [7:0] d);
    wait_cyc(at - 1);
    reg_addr = a; reg_wdata = d; reg_wr = wr; reg_rd = !wr;
    wait_cyc(at);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic drive_rx(input int t0, input logic [7:0] b, input int d);
    for (int k = 0; k < 10; k++) begin
      wait_cyc(t0 + k * d);
      rx_drv = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
    end
  endtask

  initial begin
    int e, d, x, b0;
    logic [7:0] byt;
    logic exp_bit;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(5);

    // R10 reset state, R11 address 3
    check(txd === 1'b1, "R10 txd idle", txd, 1);
    bus(cyc + 1, 0, 2'd0, 8'h00); check(reg_rdata === 8'h00, "R10 ctrl", reg_rdata, 8'h00);
    bus(cyc + 1, 0, 2'd1, 8'h00); check(reg_rdata === 8'h10, "R10 status", reg_rdata, 8'h10);
    bus(cyc + 1, 0, 2'd2, 8'h00); check(reg_rdata === 8'h00, "R10 data", reg_rdata, 8'h00);
    bus(cyc + 1, 0, 2'd3, 8'h00); check(reg_rdata === 8'h00, "R11 addr3", reg_rdata, 8'h00);

    // R11 read latency: value appears only after the strobe edge
    bus(cyc + 1, 0, 2'd1, 8'h00);
    bus(cyc + 1, 1, 2'd0, 8'h63);
    wait_cyc(cyc + 1);
    check(reg_rdata === 8'h10, "R11 hold before read", reg_rdata, 8'h10);
    bus(cyc + 1, 0, 2'd0, 8'h00);
    check(reg_rdata === 8'h63, "R11 read after edge", reg_rdata, 8'h63);

    // Vector table: all rate codes, loopback transmit and receive
    lb = 1'b1;
    for (int v = 0; v < 8; v++) begin
      byt = VEC[v][15:8];
      d   = int'(VEC[v][7:0]);
      bus(cyc + 1, 1, 2'd0, {5'b01100, VEC[v][18:16]});
      e = cyc + 3;
      bus(e, 1, 2'd2, byt);
      for (int k = 0; k < 10; k++) begin
        x = e + k * d + d / 2;
        exp_bit = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : byt[k-1];
        if (k == 6) begin
          bus(x, 0, 2'd1, 8'h00);
          check(reg_rdata[2:0] === 3'd5, "R8 bit count", reg_rdata[2:0], 5);
          check(reg_rdata[4] === 1'b0, "R3 busy sending", reg_rdata[4], 0);
        end else begin
          wait_cyc(x);
        end
        check(txd === exp_bit, "R2 frame bit", txd, exp_bit);
      end
      bus(e + 10 * d, 0, 2'd1, 8'h00);
      check(reg_rdata[4] === 1'b0, "R1 R3 ready still low", reg_rdata[4], 0);
      bus(e + 10 * d + 1, 0, 2'd1, 8'h00);
      check(reg_rdata[4] === 1'b1, "R1 R3 ready back", reg_rdata[4], 1);
      bus(e + 10 * d + d / 2 + 6, 0, 2'd1, 8'h00);
      check(reg_rdata[5] === 1'b1, "R5 byte available", reg_rdata[5], 1);
      bus(cyc + 1, 0, 2'd2, 8'h00);
      check(reg_rdata === byt, "R5 R7 received byte", reg_rdata, byt);
      bus(cyc + 1, 0, 2'd1, 8'h00);
      check(reg_rdata[5] === 1'b0, "R7 avail cleared", reg_rdata[5], 0);
    end

    // R4: transmit mode off, write ignored
    bus(cyc + 1, 1, 2'd0, 8'h04);
    e = cyc + 2;
    bus(e, 1, 2'd2, 8'h00);
    wait_cyc(e + 5);
    check(txd === 1'b1, "R4 tx mode off", txd, 1);
    bus(cyc + 1, 0, 2'd1, 8'h00);
    check(reg_rdata[4] === 1'b1, "R4 ready unchanged", reg_rdata[4], 1);

    // R4: second write while sending is ignored (first byte 0x00 goes out)
    bus(cyc + 1, 1, 2'd0, 8'h24);
    e = cyc + 3;
    bus(e, 1, 2'd2, 8'h00);
    bus(e + 1, 1, 2'd2, 8'hFF);
    for (int k = 1; k < 9; k++) begin
      wait_cyc(e + k * 11 + 5);
      check(txd === 1'b0, "R4 write while busy ignored", txd, 0);
    end
    wait_cyc(e + 120);

    // R5: receive mode off, loopback frame not captured
    bus(cyc + 1, 1, 2'd2, 8'h77);
    wait_cyc(cyc + 130);
    bus(cyc + 1, 0, 2'd1, 8'h00);
    check(reg_rdata[5] === 1'b0, "R5 rx mode off", reg_rdata[5], 0);

    // R6: short low glitch rejected
    lb = 1'b0;
    bus(cyc + 1, 1, 2'd0, 8'h44);
    wait_cyc(cyc + 3);
    rx_drv = 1'b0;
    wait_cyc(cyc + 2);
    rx_drv = 1'b1;
    wait_cyc(cyc + 150);
    bus(cyc + 1, 0, 2'd1, 8'h00);
    check(reg_rdata[5] === 1'b0, "R6 glitch dropped", reg_rdata[5], 0);

    // R5: externally driven frame
    b0 = cyc + 2;
    drive_rx(b0, 8'h6D, 11);
    wait_cyc(b0 + 120);
    bus(cyc + 1, 0, 2'd2, 8'h00);
    check(reg_rdata === 8'h6D, "R5 external byte", reg_rdata, 8'h6D);

    // R5: bad stop bit discards byte
    b0 = cyc + 2;
    drive_rx(b0, 8'h12, 11);
    rx_drv = 1'b0;
    wait_cyc(b0 + 9 * 11 + 11);
    rx_drv = 1'b1;
    wait_cyc(b0 + 140);
    bus(cyc + 1, 0, 2'd1, 8'h00);
    check(reg_rdata[5] === 1'b0, "R5 framing error dropped", reg_rdata[5], 0);

    // R9: busy aborts a frame, self-clears after 16 cycles
    bus(cyc + 1, 1, 2'd0, 8'h24);
    e = cyc + 3;
    bus(e, 1, 2'd2, 8'h00);
    x = e + 30;
    bus(x, 1, 2'd0, 8'hA4);
    bus(x + 2, 0, 2'd1, 8'h00);
    check(txd === 1'b1, "R9 txd released", txd, 1);
    check(reg_rdata[4] === 1'b1 && reg_rdata[2:0] === 3'd0, "R9 status cleared",
          reg_rdata, 8'h10);
    bus(x + 5, 1, 2'd2, 8'h00);
    bus(x + 16, 0, 2'd0, 8'h00);
    check(reg_rdata === 8'hA4, "R9 busy held", reg_rdata, 8'hA4);
    bus(x + 17, 0, 2'd0, 8'h00);
    check(reg_rdata === 8'h24, "R9 busy cleared", reg_rdata, 8'h24);
    wait_cyc(x + 25);
    check(txd === 1'b1, "R9 write during busy ignored", txd, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule